// File: doc/BRIEF.md
# Linked Frame Descriptor Fetcher

This block is the front end of one display DMA channel. Every frame buffer is described by a four-word descriptor in memory. The words are, in order: the address of the next descriptor, the frame source address, a frame identifier and a command word. When a start trigger arrives, the block works out which descriptor to read. It uses the stored next-descriptor pointer, unless a one-shot branch has been armed in the branch register. It checks that address against an allowed memory window and then reads the four words, one request at a time. It then presents the frame's source address, identifier, length and palette flag to the pixel mover that follows it.

The command word gates the frame events. Start-of-frame and end-of-frame are only reported when their enable bits are set, and a palette load never reports either. A frame whose source address is zero or lies outside the window produces a bus-error event instead of a transfer. Pixel movement and interrupt routing sit outside this block. The block only emits one-cycle event pulses for them.

Top module: `desc_chain_fetcher`

## Requirements
- R1: A write with `cfg_sel`=0 loads the next-descriptor pointer with bits 3:0 forced to zero. A write with `cfg_sel`=1 loads the branch register masked with 0xFFFFFFF3. Both take effect on the `desc_ptr`/`branch_reg` outputs one cycle after the write.
- R2: A start trigger is ignored while `chan_en` is low or while a fetch or frame is in progress. An ignored trigger issues no memory request and raises no event.
- R3: If branch bit 0 is set when a fetch starts, the descriptor address is branch bits 31:4 (low nibble zero), and branch bit 0 is cleared. Otherwise the next-descriptor pointer is used. Words are read at address +0, +4, +8 and +12.
- R4: When a branch is taken with branch bit 1 set, `ev_branch` pulses in the cycle after the trigger edge. There is no pulse when bit 1 is clear or when no branch is taken.
- R5: If descriptor address + 16 exceeds window base + window size, or the address is below the base, no memory request is made. The source address is cleared to zero and `ev_buserr` pulses one cycle after the trigger edge.
- R6: Only one read is outstanding. A request holds its address until granted, and the next request waits for the response.
- R7: After the fourth word, the pointer holds word 0. `src_addr`, `frame_id` and `cmd_word` take words 1 to 3, `xfer_len` is command bits 20:2 times 4, and `pal_load` is command bit 26. `frame_id` does not change from then until the next fetch completes.
- R8: A fetched source that is zero, or lies outside [base, base+size], pulses `ev_buserr` instead of starting the frame. There is no start-of-frame event, and the block returns to idle.
- R9: For a non-palette frame, `ev_sof` pulses one cycle after the fetch completes, only if command bit 22 is set. `ev_eof` pulses in the cycle after `frame_done` is seen, only if command bit 21 is set. `frame_done` is ignored outside an active frame.
- R10: A palette frame (command bit 26 set) raises neither start-of-frame nor end-of-frame events, whatever bits 22 and 21 hold.
- R11: Every event output is a pulse exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects next-descriptor pointer, 1 selects branch register |
| cfg_wdata | input | 32 | Register write data |
| chan_en | input | 1 | Channel enable |
| sof_trig | input | 1 | Start a descriptor fetch |
| frame_done | input | 1 | Downstream transfer of the frame has finished |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Word read address |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| desc_ptr | output | 32 | Current next-descriptor pointer |
| branch_reg | output | 32 | Current branch register |
| src_addr | output | 32 | Frame source address |
| frame_id | output | 32 | Frame identifier |
| cmd_word | output | 32 | Frame command word |
| xfer_len | output | 32 | Transfer length in bytes |
| pal_load | output | 1 | Current frame is a palette load |
| frame_active | output | 1 | A frame is being transferred |
| ev_sof | output | 1 | Start-of-frame event pulse |
| ev_eof | output | 1 | End-of-frame event pulse |
| ev_branch | output | 1 | Branch-taken event pulse |
| ev_buserr | output | 1 | Bus-error event pulse |

## Verification
With a memory that grants at once and answers one cycle later, each word costs two cycles. The branch pulse is due in the cycle after the trigger edge and a rejected descriptor's bus error one cycle later. A fetched frame's start-of-frame or bus-error pulse arrives nine cycles after the trigger edge, and end-of-frame in the cycle after `frame_done` is sampled. The bench stamps the cycle of every trigger and done edge and of every event pulse, and compares these against the expected offsets. A separate stalled-grant scenario checks only the fetched values and the request hold, since its timing is stretched on purpose.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int DESC_BYTES = DESC_WORDS * (WORD_W / 8);

    typedef logic [WORD_W-1:0] word_t;

    // register select
    localparam logic SEL_NEXT   = 1'b0;
    localparam logic SEL_BRANCH = 1'b1;

    // branch register bits
    localparam int BR_ACTIVE = 0;
    localparam int BR_NOTIFY = 1;

    // command word bits
    localparam int CMD_EOF_EN = 21;
    localparam int CMD_SOF_EN = 22;
    localparam int CMD_PAL    = 26;

    // event vector positions
    localparam int EV_SOF    = 0;
    localparam int EV_EOF    = 1;
    localparam int EV_BRANCH = 2;
    localparam int EV_BUSERR = 3;
    localparam int NUM_EV    = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ0, S_REQ1, S_REQ2, S_REQ3, S_CHECK, S_ACTIVE
    } fsm_e;

    typedef struct packed {
        word_t src;
        word_t id;
        word_t cmd;
    } frame_info_t;

    function automatic word_t mask_next(input word_t w);
        return w & 32'hFFFF_FFF0;
    endfunction

    function automatic word_t mask_branch(input word_t w);
        return w & 32'hFFFF_FFF3;
    endfunction

    function automatic word_t cmd_length(input word_t c);
        return c & 32'h001F_FFFC;
    endfunction

    function automatic logic desc_in_window(input word_t a, input word_t base, input word_t size);
        logic [WORD_W:0] lo, hi, ea;
        lo = {1'b0, base};
        hi = {1'b0, base} + {1'b0, size};
        ea = {1'b0, a};
        return (ea >= lo) && (ea + (WORD_W+1)'(DESC_BYTES) <= hi);
    endfunction

    function automatic logic src_in_window(input word_t a, input word_t base, input word_t size);
        logic [WORD_W:0] lo, hi, ea;
        lo = {1'b0, base};
        hi = {1'b0, base} + {1'b0, size};
        ea = {1'b0, a};
        return (a != '0) && (ea >= lo) && (ea <= hi);
    endfunction

    function automatic logic is_req(input fsm_e s);
        return (s == S_REQ0) || (s == S_REQ1) || (s == S_REQ2) || (s == S_REQ3);
    endfunction

    function automatic logic [IDX_W-1:0] req_index(input fsm_e s);
        case (s)
            S_REQ1:  return IDX_W'(1);
            S_REQ2:  return IDX_W'(2);
            S_REQ3:  return IDX_W'(3);
            default: return IDX_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/fdf_regs.sv
module fdf_regs
    import fdf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cfg_we,
    input  logic  cfg_sel,
    input  word_t cfg_wdata,
    input  logic  take_branch,
    input  logic  nd_load,
    input  word_t nd_value,
    output word_t nd_q,
    output word_t br_q
);

    logic wr_next, wr_branch;
    assign wr_next   = cfg_we && (cfg_sel == SEL_NEXT);
    assign wr_branch = cfg_we && (cfg_sel == SEL_BRANCH);

    // software write wins over a fetch update in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            nd_q <= '0;
        end else if (wr_next) begin
            nd_q <= mask_next(cfg_wdata);
        end else if (nd_load) begin
            nd_q <= nd_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            br_q <= '0;
        end else if (wr_branch) begin
            br_q <= mask_branch(cfg_wdata);
        end else if (take_branch) begin
            br_q[BR_ACTIVE] <= 1'b0;
        end
    end

    assert_next_masked_R1: assert property (@(posedge clk) disable iff (rst)
        wr_next |=> (nd_q[3:0] == 4'h0) && (nd_q[WORD_W-1:4] == $past(cfg_wdata[WORD_W-1:4])));

    assert_branch_masked_R1: assert property (@(posedge clk) disable iff (rst)
        wr_branch |=> (br_q[3:2] == 2'b00));

    assert_branch_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (take_branch && !cfg_we) |=> !br_q[BR_ACTIVE]);

endmodule

// File: rtl/fdf_fetch.sv
module fdf_fetch
    import fdf_pkg::*;
#(
    parameter word_t WIN_BASE = 32'h1000_0000,
    parameter word_t WIN_SIZE = 32'h0001_0000
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        sof_trig,
    input  logic        chan_en,
    input  logic        frame_done,
    input  word_t       nd_q,
    input  word_t       br_q,
    output logic        mem_req,
    output word_t       mem_addr,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  word_t       mem_rdata,
    output logic        take_branch,
    output logic        nd_load,
    output word_t       nd_value,
    output frame_info_t info,
    output logic        active,
    output logic [NUM_EV-1:0] ev_req
);

    fsm_e              state_q;
    logic              wait_q;
    word_t             base_q;
    word_t             stage_src_q, stage_id_q;
    frame_info_t       info_q;

    logic              fetch_start, in_req, resp, src_ok, pal, desc_ok;
    logic [IDX_W-1:0]  idx;
    word_t             desc_addr;

    assign fetch_start = (state_q == S_IDLE) && sof_trig && chan_en;
    assign desc_addr   = br_q[BR_ACTIVE] ? (br_q & 32'hFFFF_FFF0) : nd_q;
    assign desc_ok     = desc_in_window(desc_addr, WIN_BASE, WIN_SIZE);
    assign take_branch = fetch_start && br_q[BR_ACTIVE];

    assign in_req   = is_req(state_q);
    assign idx      = req_index(state_q);
    assign mem_req  = in_req && !wait_q;
    assign mem_addr = base_q + {{(WORD_W-IDX_W-2){1'b0}}, idx, 2'b00};
    assign resp     = in_req && wait_q && mem_rvalid;

    assign nd_load  = resp && (idx == IDX_W'(0));
    assign nd_value = mem_rdata;

    assign src_ok = src_in_window(info_q.src, WIN_BASE, WIN_SIZE);
    assign pal    = info_q.cmd[CMD_PAL];

    always_comb begin
        ev_req            = '0;
        ev_req[EV_SOF]    = (state_q == S_CHECK) && src_ok && !pal && info_q.cmd[CMD_SOF_EN];
        ev_req[EV_EOF]    = (state_q == S_ACTIVE) && frame_done && !pal && info_q.cmd[CMD_EOF_EN];
        ev_req[EV_BRANCH] = take_branch && br_q[BR_NOTIFY];
        ev_req[EV_BUSERR] = (state_q == S_CHECK) && !src_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            wait_q      <= 1'b0;
            base_q      <= '0;
            stage_src_q <= '0;
            stage_id_q  <= '0;
            info_q      <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (fetch_start) begin
                        if (desc_ok) begin
                            base_q  <= desc_addr;
                            wait_q  <= 1'b0;
                            state_q <= S_REQ0;
                        end else begin
                            info_q.src <= '0;
                            state_q    <= S_CHECK;
                        end
                    end
                end
                S_REQ0, S_REQ1, S_REQ2, S_REQ3: begin
                    if (mem_req && mem_gnt) begin
                        wait_q <= 1'b1;
                    end
                    if (resp) begin
                        wait_q <= 1'b0;
                        case (state_q)
                            S_REQ0: state_q <= S_REQ1;
                            S_REQ1: begin
                                stage_src_q <= mem_rdata;
                                state_q     <= S_REQ2;
                            end
                            S_REQ2: begin
                                stage_id_q <= mem_rdata;
                                state_q    <= S_REQ3;
                            end
                            default: begin
                                info_q.src <= stage_src_q;
                                info_q.id  <= stage_id_q;
                                info_q.cmd <= mem_rdata;
                                state_q    <= S_CHECK;
                            end
                        endcase
                    end
                end
                S_CHECK: state_q <= src_ok ? S_ACTIVE : S_IDLE;
                S_ACTIVE: if (frame_done) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign info   = info_q;
    assign active = (state_q == S_ACTIVE);

    assert_req_held_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_gnt) |=> !mem_req);

    assert_bad_desc_no_req_R5: assert property (@(posedge clk) disable iff (rst)
        (fetch_start && !desc_ok) |=> (!mem_req && info_q.src == '0));

    assert_id_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_REQ3) |=> $stable(info_q.id));

    assert_trig_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && !chan_en) |=> (state_q == S_IDLE));

endmodule

// File: rtl/fdf_events.sv
module fdf_events
    import fdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_EV-1:0] ev_req,
    output logic [NUM_EV-1:0] ev_q
);

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        always_ff @(posedge clk) begin
            if (rst) ev_q[i] <= 1'b0;
            else     ev_q[i] <= ev_req[i];
        end

        assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
            ev_q[i] |=> !ev_q[i]);
    end

endmodule

// File: rtl/desc_chain_fetcher.sv
module desc_chain_fetcher
    import fdf_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h1000_0000,
    parameter logic [31:0] WIN_SIZE = 32'h0001_0000
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        chan_en,
    input  logic        sof_trig,
    input  logic        frame_done,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic [31:0] desc_ptr,
    output logic [31:0] branch_reg,
    output logic [31:0] src_addr,
    output logic [31:0] frame_id,
    output logic [31:0] cmd_word,
    output logic [31:0] xfer_len,
    output logic        pal_load,
    output logic        frame_active,
    output logic        ev_sof,
    output logic        ev_eof,
    output logic        ev_branch,
    output logic        ev_buserr
);

    word_t             nd_q, br_q, nd_value;
    logic              take_branch, nd_load;
    frame_info_t       info;
    logic [NUM_EV-1:0] ev_req, ev_q;

    fdf_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .take_branch (take_branch),
        .nd_load     (nd_load),
        .nd_value    (nd_value),
        .nd_q        (nd_q),
        .br_q        (br_q)
    );

    fdf_fetch #(
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .sof_trig    (sof_trig),
        .chan_en     (chan_en),
        .frame_done  (frame_done),
        .nd_q        (nd_q),
        .br_q        (br_q),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_gnt     (mem_gnt),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .take_branch (take_branch),
        .nd_load     (nd_load),
        .nd_value    (nd_value),
        .info        (info),
        .active      (frame_active),
        .ev_req      (ev_req)
    );

    fdf_events u_events (
        .clk    (clk),
        .rst    (rst),
        .ev_req (ev_req),
        .ev_q   (ev_q)
    );

    assign desc_ptr   = nd_q;
    assign branch_reg = br_q;
    assign src_addr   = info.src;
    assign frame_id   = info.id;
    assign cmd_word   = info.cmd;
    assign xfer_len   = cmd_length(info.cmd);
    assign pal_load   = info.cmd[CMD_PAL];

    assign ev_sof    = ev_q[EV_SOF];
    assign ev_eof    = ev_q[EV_EOF];
    assign ev_branch = ev_q[EV_BRANCH];
    assign ev_buserr = ev_q[EV_BUSERR];

    assert_err_excludes_sof_R8: assert property (@(posedge clk) disable iff (rst)
        !(ev_buserr && ev_sof));

    assert_eof_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        ev_eof |-> $past(frame_done));

    assert_palette_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (ev_sof || ev_eof) |-> !pal_load);

    assert_branch_notify_R4: assert property (@(posedge clk) disable iff (rst)
        ev_branch |-> ($past(branch_reg[1]) && $past(branch_reg[0]) && $fell(branch_reg[0])));

endmodule

// File: tb/desc_chain_fetcher_test.sv
`timescale 1ns/1ps
module desc_chain_fetcher_test;

    localparam logic [31:0] WB = 32'h1000_0000;
    localparam logic [31:0] WS = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        chan_en = 1'b1, sof_trig = 1'b0, frame_done = 1'b0;
    logic        mem_req, mem_gnt, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic [31:0] desc_ptr, branch_reg, src_addr, frame_id, cmd_word, xfer_len;
    logic        pal_load, frame_active, ev_sof, ev_eof, ev_branch, ev_buserr;
    logic        gnt_en = 1'b1;

    always #2 clk = ~clk;

    desc_chain_fetcher #(.WIN_BASE(WB), .WIN_SIZE(WS)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .chan_en(chan_en), .sof_trig(sof_trig), .frame_done(frame_done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .desc_ptr(desc_ptr), .branch_reg(branch_reg), .src_addr(src_addr),
        .frame_id(frame_id), .cmd_word(cmd_word), .xfer_len(xfer_len),
        .pal_load(pal_load), .frame_active(frame_active),
        .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_branch(ev_branch), .ev_buserr(ev_buserr)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [0:63];
    assign mem_gnt = mem_req && gnt_en;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (a >= WB && a < WB + 32'd256) return mem[(a - WB) >> 2];
        return 32'hBAD0_0000;
    endfunction

    int cyc = 0, trig_at = 0, done_at = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (sof_trig)   trig_at <= cyc + 1;
        if (frame_done) done_at <= cyc + 1;
        mem_rvalid <= mem_req && mem_gnt;
        mem_rdata  <= rd(mem_addr);
    end

    // ---------------- scoreboard ----------------
    int tests = 0, fails = 0;
    int n_sof, n_eof, n_br, n_err, sof_at, eof_at, br_at, err_at, nreq;
    logic [31:0] rlog [0:7];
    logic p_sof = 0, p_eof = 0, p_br = 0, p_err = 0, p_pend = 0;
    logic [31:0] p_addr = '0;
    bit summary_done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (ev_sof)    begin n_sof++; sof_at = cyc; end
            if (ev_eof)    begin n_eof++; eof_at = cyc; end
            if (ev_branch) begin n_br++;  br_at  = cyc; end
            if (ev_buserr) begin n_err++; err_at = cyc; end
            if (ev_sof || ev_eof || ev_branch || ev_buserr) begin
                chk("R11 pulse width", {28'd0, p_sof & ev_sof, p_eof & ev_eof, p_br & ev_branch, p_err & ev_buserr}, 32'd0);
            end
            if (p_pend) begin
                chk("R6 request held", {31'd0, mem_req}, 32'd1);
                chk("R6 address held", mem_addr, p_addr);
            end
            if (mem_req && mem_gnt) begin
                if (nreq < 8) rlog[nreq] = mem_addr;
                nreq++;
            end
            p_sof = ev_sof; p_eof = ev_eof; p_br = ev_branch; p_err = ev_buserr;
            p_pend = mem_req && !mem_gnt;
            p_addr = mem_addr;
        end
    end

    task automatic clr();
        n_sof = 0; n_eof = 0; n_br = 0; n_err = 0; nreq = 0;
        sof_at = -1; eof_at = -1; br_at = -1; err_at = -1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic trig();
        @(negedge clk); sof_trig = 1'b1;
        @(negedge clk); sof_trig = 1'b0;
    endtask

    task automatic done();
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic put_desc(input int w, input logic [31:0] nx, s, id, cm);
        mem[w] = nx; mem[w+1] = s; mem[w+2] = id; mem[w+3] = cm;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R7 reset src", src_addr, 0);
        chk("R7 reset id", frame_id, 0);
        chk("R1 reset ptr", desc_ptr, 0);
        chk("R11 reset events", {28'd0, ev_sof, ev_eof, ev_branch, ev_buserr}, 0);
        chk("R6 reset req", {31'd0, mem_req}, 0);
    endtask

    task automatic t_regs();
        wr(1'b0, WB + 32'h47);
        chk("R1 next mask", desc_ptr, WB + 32'h40);
        wr(1'b1, 32'hFFFF_FFFF);
        chk("R1 branch mask", branch_reg, 32'hFFFF_FFF3);
        wr(1'b1, 32'h0);
        wr(1'b0, WB);
    endtask

    task automatic t_plain();
        clr(); trig(); idle(11);
        chk("R9 sof count", n_sof, 1);
        chk("R9 sof cycle", sof_at, trig_at + 9);
        chk("R3 req count", nreq, 4);
        for (int k = 0; k < 4; k++) chk("R3 word address", rlog[k], WB + 32'(4*k));
        chk("R7 src", src_addr, WB + 32'h1000);
        chk("R7 id", frame_id, 32'hA5);
        chk("R7 len", xfer_len, 32'h400);
        chk("R7 next ptr", desc_ptr, WB + 32'h20);
        chk("R4 no branch event", n_br, 0);
        chk("R7 active", {31'd0, frame_active}, 1);
        trig(); idle(6);
        chk("R2 busy trigger ignored", nreq, 4);
        done(); idle(2);
        chk("R9 eof count", n_eof, 1);
        chk("R9 eof cycle", eof_at, done_at);
        chk("R9 idle after", {31'd0, frame_active}, 0);
        done(); idle(2);
        chk("R9 done ignored when idle", n_eof, 1);
    endtask

    task automatic t_chain();
        clr(); trig(); idle(3);
        chk("R7 id stable during fetch", frame_id, 32'hA5);
        idle(8);
        chk("R3 chained address", rlog[0], WB + 32'h20);
        chk("R7 chained id", frame_id, 32'h1B);
        chk("R9 sof disabled", n_sof, 0);
        done(); idle(2);
        chk("R9 eof disabled", n_eof, 0);
    endtask

    task automatic t_branch();
        wr(1'b1, WB + 32'h43);
        clr(); trig(); idle(11);
        chk("R4 branch event", n_br, 1);
        chk("R4 branch cycle", br_at, trig_at);
        chk("R3 branch cleared", branch_reg, WB + 32'h42);
        chk("R3 branch address", rlog[0], WB + 32'h40);
        chk("R7 branch id", frame_id, 32'h2C);
        chk("R9 branch sof", n_sof, 1);
        done(); idle(2);
        wr(1'b1, WB + 32'h62);
        clr(); trig(); idle(11);
        chk("R4 notify without active", n_br, 0);
        chk("R3 pointer used", rlog[0], WB);
        chk("R3 branch untouched", branch_reg, WB + 32'h62);
        done(); idle(2);
    endtask

    task automatic t_palette();
        wr(1'b0, WB + 32'h60);
        clr(); trig(); idle(11);
        chk("R7 palette flag", {31'd0, pal_load}, 1);
        chk("R7 palette len", xfer_len, 32'h7FC);
        chk("R10 no sof", n_sof, 0);
        chk("R10 active", {31'd0, frame_active}, 1);
        done(); idle(2);
        chk("R10 no eof", n_eof, 0);
    endtask

    task automatic t_bad_src();
        wr(1'b0, WB + 32'h80);
        clr(); trig(); idle(12);
        chk("R8 zero src error", n_err, 1);
        chk("R8 error cycle", err_at, trig_at + 9);
        chk("R8 no sof", n_sof, 0);
        chk("R8 idle", {31'd0, frame_active}, 0);
        wr(1'b0, WB + 32'hA0);
        clr(); trig(); idle(12);
        chk("R8 far src error", n_err, 1);
        chk("R8 far no sof", n_sof, 0);
    endtask

    task automatic t_bad_desc();
        wr(1'b0, 32'h0000_1000);
        clr(); trig(); idle(4);
        chk("R5 no request", nreq, 0);
        chk("R5 error", n_err, 1);
        chk("R5 error cycle", err_at, trig_at + 1);
        chk("R5 src cleared", src_addr, 0);
        wr(1'b0, WB + WS);
        clr(); trig(); idle(4);
        chk("R5 top edge out", nreq, 0);
        chk("R5 top edge error", n_err, 1);
        wr(1'b0, WB + WS - 32'd16);
        clr(); trig(); idle(12);
        chk("R5 last slot fetched", nreq, 4);
        chk("R8 junk src error", n_err, 1);
    endtask

    task automatic t_disabled();
        wr(1'b0, WB);
        chan_en = 1'b0;
        clr(); trig(); idle(15);
        chk("R2 disabled no request", nreq, 0);
        chk("R2 disabled no event", n_sof + n_err + n_br, 0);
        chk("R2 disabled idle", {31'd0, frame_active}, 0);
        chan_en = 1'b1;
    endtask

    task automatic t_stall();
        wr(1'b0, WB);
        gnt_en = 1'b0;
        clr(); trig(); idle(5);
        chk("R6 stalled request", {31'd0, mem_req}, 1);
        chk("R6 stalled address", mem_addr, WB);
        chk("R6 nothing accepted", nreq, 0);
        gnt_en = 1'b1;
        idle(14);
        chk("R6 all words after stall", nreq, 4);
        chk("R7 id after stall", frame_id, 32'hA5);
        done(); idle(2);
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        put_desc(0,  WB + 32'h20, WB + 32'h1000, 32'hA5, 32'h0060_0400);
        put_desc(8,  WB,          WB + 32'h2000, 32'h1B, 32'h0000_0100);
        put_desc(16, WB,          WB + 32'h3000, 32'h2C, 32'h0040_0200);
        put_desc(24, WB,          WB + 32'h4000, 32'h3D, 32'h0460_07FC);
        put_desc(32, WB,          32'h0,         32'h4E, 32'h0060_0100);
        put_desc(40, WB,          32'h2000_0000, 32'h5F, 32'h0060_0100);
        clr();
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset();
        t_regs();
        t_plain();
        t_chain();
        t_branch();
        t_palette();
        t_bad_src();
        t_bad_desc();
        t_disabled();
        t_stall();
        idle(2);
        summary();
    end

    initial begin
        #(4 * 100000);
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
    end

endmodule